// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches the running minute, hour, day-of-month and weekday of a real-time clock and raises an alarm when the clock steps into a moment that agrees with a programmed alarm time. The clock counters live outside the block. It receives their current values, BCD coded, together with a one-cycle strobe that marks each time increment. Every alarm field has its own skip bit, so an alarm can fire, for example, every hour at minute 30, or on a given weekday at a given hour.

The alarm event is latched in a sticky flag. Host software clears the flag through a small register write port. An active-low interrupt output mirrors the flag while the interrupt enable is set. The flag is set only on an increment strobe whose post-increment time matches. A match that simply persists does not set it, and neither does a match created by reprogramming the alarm.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, registers 0 to 3 read 0x80, so every field is skipped with value 0. Register 4 reads 0x00 and irq_n is 1.
- R2: The register map is as follows. Address 0 is the minute alarm (bits 6:0), address 1 the hour (bits 5:0), address 2 the day (bits 5:0) and address 3 the weekday (bits 2:0). In each of these, bit 7 is the skip bit and the unused bits read 0. Address 4 is control: bit 0 is the alarm flag and bit 1 is the interrupt enable. Addresses 5 to 7 read 0x00, and writes to them have no effect.
- R3: On a cycle with tick high, the flag becomes 1 when every field whose skip bit is 0 equals the corresponding time input. Fields whose skip bit is 1 take no part in the comparison.
- R4: Without tick, the flag is never set. This holds both when the time inputs already match and when a write makes the alarm equal to the current time.
- R5: Once set, the flag stays 1 until a write to address 4 with bit 0 equal to 0. A write with bit 0 equal to 1 leaves the flag unchanged.
- R6: After a clear, the flag is set again only on a later tick whose time matches.
- R7: irq_n is 0 exactly while both the flag and the interrupt enable are 1. It returns to 1 in the cycle after the edge at which a clear or an enable-off write takes effect.
- R8: When all four skip bits are 1, no tick ever sets the flag.
- R9: When a clearing write and a matching tick fall in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe: time inputs hold the new, incremented time |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday, 0 to 6 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
A host clear of the flag and a tick whose new time matches the alarm can land on the same clock edge. The bench provokes this both in a directed case and repeatedly during randomized sweeps. In those sweeps, clear writes are scattered over cycles in which the time inputs are biased toward the alarm values. A reference flag model, in which a set overrides a clear, judges every cycle. The bench reads the flag, the enable and irq_n at the ports after each edge.

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [6:0]    cur_min,
  input  logic [5:0]    cur_hour,
  input  logic [5:0]    cur_day,
  input  logic [2:0]    cur_wday,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          irq_n
);
  localparam logic [AW-1:0] A_MIN  = AW'(0);
  localparam logic [AW-1:0] A_HOUR = AW'(1);
  localparam logic [AW-1:0] A_DAY  = AW'(2);
  localparam logic [AW-1:0] A_WDAY = AW'(3);
  localparam logic [AW-1:0] A_CTRL = AW'(4);

  logic [6:0] al_min;
  logic [5:0] al_hour;
  logic [5:0] al_day;
  logic [2:0] al_wday;
  logic [3:0] skip;
  logic       ie_q;
  logic       flag_q;

  logic [3:0] hit;
  logic       match;
  logic       set_now;
  logic       clr_now;

  assign hit[0] = skip[0] | (al_min  == cur_min);
  assign hit[1] = skip[1] | (al_hour == cur_hour);
  assign hit[2] = skip[2] | (al_day  == cur_day);
  assign hit[3] = skip[3] | (al_wday == cur_wday);

  assign match   = (&hit) & ~(&skip);
  assign set_now = tick & match;
  assign clr_now = wr_en & (wr_addr == A_CTRL) & ~wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_min  <= '0;
      al_hour <= '0;
      al_day  <= '0;
      al_wday <= '0;
      skip    <= '1;
      ie_q    <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MIN:  begin al_min  <= wr_data[6:0]; skip[0] <= wr_data[7]; end
        A_HOUR: begin al_hour <= wr_data[5:0]; skip[1] <= wr_data[7]; end
        A_DAY:  begin al_day  <= wr_data[5:0]; skip[2] <= wr_data[7]; end
        A_WDAY: begin al_wday <= wr_data[2:0]; skip[3] <= wr_data[7]; end
        A_CTRL: ie_q <= wr_data[1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_now) flag_q <= 1'b1;
    else if (clr_now) flag_q <= 1'b0;
  end

  assign irq_n = ~(flag_q & ie_q);

  always_comb begin
    case (rd_addr)
      A_MIN:   rd_data = {skip[0], al_min};
      A_HOUR:  rd_data = {skip[1], 1'b0, al_hour};
      A_DAY:   rd_data = {skip[2], 1'b0, al_day};
      A_WDAY:  rd_data = {skip[3], 4'b0, al_wday};
      A_CTRL:  rd_data = {6'b0, ie_q, flag_q};
      default: rd_data = 8'h00;
    endcase
  end

  p_set_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_en && wr_addr == A_CTRL)) |=> flag_q);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_now && !tick) |=> !flag_q);

  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && ie_q) |-> !irq_n);

  p_all_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&skip && !flag_q && !(wr_en && wr_addr <= A_WDAY)) |=> !flag_q);
endmodule

// File: tb/test_cal_alarm_match.sv
module test_cal_alarm_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [5:0] cur_day = '0;
  logic [2:0] cur_wday = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = 3'd4;
  logic [7:0] rd_data;
  logic       irq_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [6:0] m_val [4];
  logic [3:0] m_skip;
  logic       m_ie;
  logic       m_flag;

  always #2 clk = ~clk;

  cal_alarm_match i_cal_alarm_match (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day), .cur_wday(cur_wday),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] mask_of(input int f);
    case (f)
      0: return 8'h7f;
      1, 2: return 8'h3f;
      default: return 8'h07;
    endcase
  endfunction

  function automatic bit m_match(input logic [6:0] mi, input logic [5:0] hr,
                                 input logic [5:0] dy, input logic [2:0] wd);
    if (&m_skip) return 0;
    return (m_skip[0] || m_val[0] == mi) && (m_skip[1] || m_val[1] == {1'b0, hr}) &&
           (m_skip[2] || m_val[2] == {1'b0, dy}) && (m_skip[3] || m_val[3] == {4'b0, wd});
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic [6:0] mi, input logic [5:0] hr,
                     input logic [5:0] dy, input logic [2:0] wd,
                     input logic w, input logic [2:0] a, input logic [7:0] d,
                     input string tag);
    bit set_m, clr_m;
    tick = t; cur_min = mi; cur_hour = hr; cur_day = dy; cur_wday = wd;
    wr_en = w; wr_addr = a; wr_data = d;
    set_m = t && m_match(mi, hr, dy, wd);
    clr_m = w && a == 3'd4 && !d[0];
    @(posedge clk);
    #1;
    if (set_m) m_flag = 1'b1;
    else if (clr_m) m_flag = 1'b0;
    if (w && a <= 3'd3) begin
      m_val[a] = 7'(d & mask_of(int'(a)));
      m_skip[a] = d[7];
    end
    if (w && a == 3'd4) m_ie = d[1];
    tick = 1'b0; wr_en = 1'b0;
    rd_addr = 3'd4;
    #0;
    chk(tag, rd_data, {6'b0, m_ie, m_flag});
    chk(tag, {7'b0, irq_n}, {7'b0, !(m_flag && m_ie)});
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
    rd_addr = 3'd4;
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    cyc(1'b0, cur_min, cur_hour, cur_day, cur_wday, 1'b1, a, d, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [6:0] tm [4];
    logic [6:0] tg [4];
    for (int i = 0; i < 4; i++) m_val[i] = '0;
    m_skip = 4'hf; m_ie = 1'b0; m_flag = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;

    // R1 reset state
    for (int a = 0; a < 4; a++) rd_chk(3'(a), 8'h80, "R1 alarm reset");
    rd_chk(3'd4, 8'h00, "R1 control reset");
    chk("R1 irq_n reset", {7'b0, irq_n}, 8'h01);

    // R2 layout: write all ones, read masked back; unused addresses
    for (int a = 0; a < 4; a++) begin
      wr(3'(a), 8'hff, "R2 write");
      rd_chk(3'(a), 8'h80 | mask_of(a), "R2 field width");
      wr(3'(a), 8'h80, "R2 restore");
    end
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hff, "R2 unused write");
      rd_chk(3'(a), 8'h00, "R2 unused read");
    end
    rd_chk(3'd4, 8'h00, "R2 control untouched");

    // R8 all skipped: sweep every minute and weekday with ticks
    for (int m = 0; m < 60; m++)
      cyc(1'b1, bcd(m), 6'h00, 6'h01, 3'(m % 7), 1'b0, 3'd0, 8'h00, "R8 all skip");

    // R3 minute-only sweep, interrupt enabled
    wr(3'd4, 8'h02, "R7 enable");
    wr(3'd0, 8'h30, "R3 program minute");
    for (int m = 0; m < 60; m++) begin
      cyc(1'b1, bcd(m), 6'h05, 6'h09, 3'd2, 1'b0, 3'd0, 8'h00, "R3 minute sweep");
      if (m_flag) begin
        chk("R7 irq low with flag", {7'b0, irq_n}, 8'h00);
        wr(3'd4, 8'h03, "R5 write one keeps flag");
        wr(3'd4, 8'h02, "R6 clear");
      end
    end

    // R4 persisting match without tick, and write creating a match
    cyc(1'b1, 7'h30, 6'h05, 6'h09, 3'd2, 1'b0, 3'd0, 8'h00, "R3 hit");
    wr(3'd4, 8'h02, "R6 clear");
    repeat (10) cyc(1'b0, 7'h30, 6'h05, 6'h09, 3'd2, 1'b0, 3'd0, 8'h00, "R4 persist no tick");
    cyc(1'b0, 7'h45, 6'h05, 6'h09, 3'd2, 1'b1, 3'd0, 8'h45, "R4 write makes match");
    repeat (3) cyc(1'b0, 7'h45, 6'h05, 6'h09, 3'd2, 1'b0, 3'd0, 8'h00, "R4 no set after write");
    cyc(1'b1, 7'h45, 6'h05, 6'h09, 3'd2, 1'b0, 3'd0, 8'h00, "R6 next tick sets");

    // R9 clear and matching tick together
    cyc(1'b1, 7'h45, 6'h05, 6'h09, 3'd2, 1'b1, 3'd4, 8'h02, "R9 set wins");
    chk("R9 flag kept", {7'b0, m_flag}, 8'h01);
    // R7 enable off releases irq
    wr(3'd4, 8'h01, "R7 enable off");
    chk("R7 irq released", {7'b0, irq_n}, 8'h01);
    wr(3'd4, 8'h00, "R5 clear");

    // R3 R9 sweep over all skip combinations with biased times
    for (int cfg = 0; cfg < 16; cfg++) begin
      tg[0] = 7'(bcd(($urandom % 60)));
      tg[1] = 7'(bcd(($urandom % 24)));
      tg[2] = 7'(bcd(1 + ($urandom % 31)));
      tg[3] = 7'($urandom % 7);
      for (int f = 0; f < 4; f++)
        wr(3'(f), {cfg[f] ? 1'b0 : 1'b1, tg[f]}, "R2 program");
      for (int n = 0; n < 300; n++) begin
        bit w;
        logic [7:0] d;
        tm[0] = ($urandom % 2) ? tg[0] : 7'(bcd($urandom % 60));
        tm[1] = ($urandom % 2) ? tg[1] : 7'(bcd($urandom % 24));
        tm[2] = ($urandom % 2) ? tg[2] : 7'(bcd(1 + ($urandom % 31)));
        tm[3] = ($urandom % 2) ? tg[3] : 7'($urandom % 7);
        w = ($urandom % 4) == 0;
        d = {6'b0, 1'($urandom % 2), 1'($urandom % 2)};
        cyc(1'($urandom % 3 != 0), tm[0], 6'(tm[1]), 6'(tm[2]), 3'(tm[3]),
            w, 3'd4, d, "R3 R5 R7 R8 R9 sweep");
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule